// File: doc/BRIEF.md
# Truncated Fixed-Point Fraction Multiplier

This block multiplies two unsigned N-bit binary fractions and returns an N-bit fraction. It never forms the full 2N-bit product. Only the partial-product bits that land in the N+K most significant columns are generated. The bits of the next lower column are added in at the weight of the lowest kept column. A fixed constant stands in for the truncation of the remaining guard bits. The result is an approximation whose absolute error stays below one unit in the last place of the N-bit output. In exchange, the low triangle of the partial-product array and the adders that would reduce it are removed.

The block is purely combinational. It suits datapaths that need a narrow product, such as iterative reciprocal or root refinement, where a full-width multiplier would waste area on bits that are then thrown away. N sets the operand and result width. K sets how many guard columns are kept below the result LSB, and must be at least 1. A larger K gives a smaller error and costs more cells.

Top module: `trunc_frac_mul`

## Requirements
- R1: Operands `a`, `b` and result `p` are unsigned fractions. Bit N-1 of each has weight 2^-1 and bit 0 has weight 2^-N. The output follows the inputs with no clock, so when both operands are at least 1/2, `p` is at least 2^-2.
- R2: A partial product a_i·b_j, with i and j counted from 1 at the operand MSB, sits in column c = i+j and has weight 2^-c. Products with c > N+K+1 have no effect on `p`. For example, a=0x0001 and b=0x0001 give p=0 at N=16, K=3.
- R3: Each partial product in column N+K+1 is added with weight 2^-(N+K), not 2^-(N+K+1). For example, a=0x0009 and b=0x1000 give p=0x0001 at N=16, K=3.
- R4: A constant of one is added in each of columns N+2 to N+K, which totals 2^(K-1)-1 units of 2^-(N+K). This constant never disturbs an exact half-operand product: for a=2^-1 (only bit N-1 set), p equals b shifted right by one.
- R5: The N+K-column sum is cut to its top N columns without rounding. For example, a=0x8000 and b=0x0001, whose exact product is half an ulp, give p=0 at N=16, K=3.
- R6: For every operand pair, |p − a·b| < 2^-N. The sum never carries past weight 2^0.
- R7: If either operand is zero, `p` is zero.
- R8: The same construction holds for other widths. At N=6, K=2, every one of the 4096 operand pairs gives the value defined by R2–R5 and meets the R6 bound.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | Multiplicand, unsigned fraction, MSB weight 2^-1 |
| b | input | N | Multiplier, unsigned fraction, MSB weight 2^-1 |
| p | output | N | Truncated product, unsigned fraction, MSB weight 2^-1 |

## Verification
The block holds no state. A wrong column mask, a misplaced fold bit or a wrong correction constant shows up at once on `p` for the operand pair that exercises it. The error usually starts as a one-ulp difference from the column-exact value, not as a breach of the error bound. For that reason every applied pair is compared against a bench model built from the column rules, and separately against the exact product. The directed pairs are chosen so that each rule flips the result LSB. A dropped or misweighted whole row breaks the bound within the first few random pairs.

// File: rtl/trunc_frac_mul.sv
module trunc_frac_mul #(
  parameter int N = 16,
  parameter int K = 3
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] p
);

  localparam int W = N + K;
  localparam logic [W-1:0] CORR = W'((2 ** (K - 1)) - 1);

  logic [W-1:0] row [N];
  logic [W-1:0] acc;
  logic [K-1:0] unused_low;

  // row j holds a*b_j at scale 2^(N+K); columns past N+K+1 never formed
  for (genvar j = 1; j <= N; j++) begin : g_row
    logic [N-1:0] pp;
    assign pp = a & {N{b[N-j]}};
    if (j <= K) begin : g_full
      assign row[j-1] = W'(pp) << (K - j);
    end else begin : g_cut
      // column N+K+1 bit is folded into column N+K
      assign row[j-1] = (W'(pp) >> (j - K)) + W'(pp[j-K-1]);
    end
  end

  always_comb begin
    acc = CORR;
    for (int r = 0; r < N; r++) acc = acc + row[r];
  end

  assign {p, unused_low} = acc;

endmodule

// File: rtl/trunc_frac_mul_chk.sv
module trunc_frac_mul_chk #(
  parameter int N = 16,
  parameter int K = 3
) (
  input logic [N-1:0] a,
  input logic [N-1:0] b,
  input logic [N-1:0] p
);

  localparam logic [2*N:0]  ULP  = {{N{1'b0}}, 1'b1, {N{1'b0}}};
  localparam logic [N-1:0]  HALF = {1'b1, {(N-1){1'b0}}};

  logic [2*N:0] exact, approx, diff;

  assign exact  = {1'b0, {N{1'b0}}, a} * {1'b0, {N{1'b0}}, b};
  assign approx = {1'b0, p, {N{1'b0}}};
  assign diff   = (approx >= exact) ? approx - exact : exact - approx;

  always_comb begin
    if (!$isunknown({a, b, p})) begin
      p_err_bound_r6: assert (diff < ULP);
      if (a == '0 || b == '0)
        p_zero_operand_r7: assert (p == '0);
      if (a == HALF)
        p_half_operand_r4: assert (p == (b >> 1));
      if (a[N-1] && b[N-1])
        p_large_operands_r1: assert (p[N-1] || p[N-2]);
    end
  end

endmodule

bind trunc_frac_mul trunc_frac_mul_chk #(.N(N), .K(K)) u_chk (.a(a), .b(b), .p(p));

// File: tb/tb_trunc_frac_mul.sv
module tb_trunc_frac_mul;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 16;
  localparam int KB = 3;
  localparam int NS = 6;
  localparam int KS = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NB-1:0] a = '0, b = '0;
  logic [NB-1:0] p;
  logic [NS-1:0] sa = '0, sb = '0;
  logic [NS-1:0] sp;

  int n_checks = 0;
  int n_fail = 0;
  longint unsigned worst_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trunc_frac_mul #(.N(NB), .K(KB)) dut (.a(a), .b(b), .p(p));
  trunc_frac_mul #(.N(NS), .K(KS)) dut_small (.a(sa), .b(sb), .p(sp));

  function automatic longint unsigned colmodel(longint unsigned av, longint unsigned bv,
                                               int n, int k);
    longint unsigned s = 0;
    for (int i = 1; i <= n; i++)
      for (int j = 1; j <= n; j++)
        if (av[n-i] && bv[n-j]) begin
          int c = i + j;
          if (c <= n + k) s += 64'd1 << (n + k - c);
          else if (c == n + k + 1) s += 64'd1;
        end
    s += (64'd1 << (k - 1)) - 64'd1;
    return (s >> k) & ((64'd1 << n) - 64'd1);
  endfunction

  task automatic chk(string req, longint unsigned act, longint unsigned exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_bound(string req, longint unsigned av, longint unsigned bv,
                           longint unsigned pv, int n);
    longint unsigned ex = av * bv;
    longint unsigned ap = pv << n;
    longint unsigned d = (ap >= ex) ? ap - ex : ex - ap;
    n_checks++;
    if (d > worst_err && n == NB) worst_err = d;
    if (d >= (64'd1 << n)) begin
      n_fail++;
      $display("FAIL %s: error 0x%0h for a=0x%0h b=0x%0h, expected below 0x%0h",
               req, d, av, bv, 64'd1 << n);
    end
  endtask

  task automatic apply(logic [NB-1:0] av, logic [NB-1:0] bv);
    @(posedge clk);
    a = av; b = bv;
    @(negedge clk);
  endtask

  task automatic t_zero;
    apply('0, '0);          chk("R7 both zero", p, 0);
    apply(16'hFFFF, '0);    chk("R7 b zero", p, 0);
    apply('0, 16'hA5C3);    chk("R7 a zero", p, 0);
  endtask

  task automatic t_columns;
    apply(16'h0001, 16'h0001); chk("R2 dropped columns", p, 16'h0000);
    apply(16'h0009, 16'h1000); chk("R3 folded column", p, 16'h0001);
    apply(16'h0010, 16'h1000); chk("R4 correction no carry", p, 16'h0001);
    apply(16'h8000, 16'h0001); chk("R5 truncation not rounding", p, 16'h0000);
    apply(16'hFFFF, 16'hFFFF);
    chk("R1 all ones model", p, colmodel(16'hFFFF, 16'hFFFF, NB, KB));
    chk_bound("R6 all ones bound", 16'hFFFF, 16'hFFFF, p, NB);
  endtask

  task automatic t_half;
    logic [NB-1:0] vals [4] = '{16'h0001, 16'h0003, 16'hFFFF, 16'h7A31};
    for (int v = 0; v < 4; v++) begin
      apply(16'h8000, vals[v]);
      chk("R4 half operand", p, vals[v] >> 1);
    end
  endtask

  task automatic t_walk;
    for (int i = 0; i < NB; i++)
      for (int j = 0; j < NB; j++) begin
        logic [NB-1:0] av = NB'(1) << i;
        logic [NB-1:0] bv = NB'(1) << j;
        apply(av, bv);
        chk("R2 walking ones", p, colmodel(av, bv, NB, KB));
      end
  endtask

  task automatic t_random;
    for (int r = 0; r < 20000; r++) begin
      logic [NB-1:0] av = NB'($urandom);
      logic [NB-1:0] bv = NB'($urandom);
      apply(av, bv);
      chk("R1 random model", p, colmodel(av, bv, NB, KB));
      chk_bound("R6 random bound", av, bv, p, NB);
    end
  endtask

  task automatic t_small;
    for (int x = 0; x < (1 << NS); x++)
      for (int y = 0; y < (1 << NS); y++) begin
        @(posedge clk);
        sa = NS'(x); sb = NS'(y);
        @(negedge clk);
        chk("R8 small model", sp, colmodel(x, y, NS, KS));
        chk_bound("R8 small bound", x, y, sp, NS);
      end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 idle output", p, 0);
    t_zero();
    t_columns();
    t_half();
    t_walk();
    t_random();
    t_small();
    $display("worst error: 0x%0h units of 2^-%0d", worst_err, 2*NB);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule